// File: doc/BRIEF.md
# Systolic Command Chain Node

This block is one station on a linear chain of processing elements. Command words of 64 bits pass from node to node and are registered once at each hop. Each node forwards every command it takes in, one cycle later. Each node is strapped with its own 5-bit identity. It acts on commands that carry its identity or the broadcast identity. It holds a bank of 48-bit configuration registers that the surrounding datapath consumes.

The chain carries the node's configuration writes, register readback and soft reset. It also carries the start requests for the three table-load phases and the compute phase, so none of these needs a dedicated wire. A readback request makes the node inject an answer word into the chain. To make room for that word, the node holds its upstream neighbour for one slot, so no command is lost. A busy signal runs backwards along the chain. A node that is told to wait freezes its output and passes the busy indication on upstream.

Top module: `cmd_chain_node`

## Requirements
- R1: While `rstN` is low, and after it is released, `downCmd` is all zero (the idle NOP word), all configuration registers are zero, `upBusy` is low and all five start or reset pulses are low.
- R2: A word on `upCmd` taken in a cycle with `upBusy` low appears unchanged on `downCmd` after the next clock edge. This holds whatever its target or opcode, including unknown opcodes and answer words from other nodes.
- R3: A command word is laid out as opcode [63:60], target identity [59:55], register index [54:51] and payload [50:0]. The node acts only when the target equals `nodeId` or equals 31 (broadcast).
- R4: Opcode 0010 (write) loads payload bits [47:0] into the register selected by the index (0 to 13). The new value is visible on `cfgRegs` (register i at bits [48*i+47:48*i]) after that edge.
- R5: A write with index 14 or 15, or with a target that does not match, leaves every configuration register unchanged.
- R6: Opcode 0111 (read) is forwarded like any other word. After the next edge, `downCmd` carries the answer word: opcode 1000, target set to this node's `nodeId`, the requested index, bits [50:48] zero and the register value in [47:0]. An index of 14 or 15 answers zero. `upBusy` is high in the cycle between the two words.
- R7: Opcode 0001 clears every configuration register and raises `resetPulse` for exactly one cycle.
- R8: Opcodes 0011, 0100, 0101 and 0110 each raise exactly one cycle of `deltaLoadStart`, `prefixLoadStart`, `commonLoadStart` and `execStart` respectively. At most one of the five pulses is high at a time.
- R9: While `downBusy` is high, `downCmd` holds its value, `upBusy` is high and `upCmd` is not taken in.
- R10: A word offered on `upCmd` while an answer is waiting is not taken in until the answer has been sent. It then takes effect one cycle later, so no command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| nodeId | input | 5 | Strapped identity of this node |
| upCmd | input | 64 | Command word from the upstream neighbour |
| upBusy | output | 1 | Hold request to the upstream neighbour |
| downCmd | output | 64 | Registered command word to the downstream neighbour |
| downBusy | input | 1 | Hold request from the downstream neighbour |
| cfgRegs | output | 672 | Configuration register bank, 14 registers of 48 bits, flattened |
| resetPulse | output | 1 | One-cycle pulse on a soft reset command |
| deltaLoadStart | output | 1 | One-cycle start of the delta-code load phase |
| prefixLoadStart | output | 1 | One-cycle start of the prefix-code load phase |
| commonLoadStart | output | 1 | One-cycle start of the common-value load phase |
| execStart | output | 1 | One-cycle start of the execute phase |

## Verification
Each write-then-read pattern pairs a write with a readback of the same index and compares the answer word with the value the write should have left. The patterns cover the lowest and highest valid indices, broadcast and foreign targets, an index beyond the bank and a payload wider than a register, so mistakes in decoding the identity, in selecting the index and in truncating the payload each show up as a different wrong answer. Directed sequences offer a new write while an answer is pending and while the downstream neighbour is busy. This separates a node that stalls correctly from one that drops or reorders words. The phase opcodes are sent one at a time to the node's own identity and to a foreign identity, which shows whether each pulse lands on the right output and only when it should.

// File: rtl/cmd_chain_pkg.sv
package cmd_chain_pkg;

  localparam int CMD_W  = 64;
  localparam int OP_W   = 4;
  localparam int ID_W   = 5;
  localparam int IDX_W  = 4;
  localparam int PAY_W  = 51;
  localparam int OP_LSB  = PAY_W + IDX_W + ID_W;
  localparam int ID_LSB  = PAY_W + IDX_W;
  localparam int IDX_LSB = PAY_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP       = 4'd0,
    OP_SOFTRST   = 4'd1,
    OP_WRITE     = 4'd2,
    OP_LDDELTA   = 4'd3,
    OP_LDPREFIX  = 4'd4,
    OP_LDCOMMON  = 4'd5,
    OP_EXEC      = 4'd6,
    OP_READ      = 4'd7,
    OP_ANSWER    = 4'd8
  } nodeOp_e;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic             take;     // upstream word is taken in this cycle
    logic             wrEn;     // write addressed to this node
    logic             clear;    // soft reset of the register bank
    logic             capture;  // build the answer word
    logic             emit;     // send the answer word downstream
    logic [IDX_W-1:0] idx;      // register index of the current word
  } nodeStrobes_t;

endpackage

// File: rtl/cmd_chain_ctrl.sv
module cmd_chain_ctrl
  import cmd_chain_pkg::*;
#(
  parameter int          ADDR_W   = ID_W,
  parameter logic [4:0]  BCAST_ID = 5'd31
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   nodeId,
  input  logic [CMD_W-1:0]    upCmd,
  input  logic                downBusy,
  output logic                upBusy,
  output nodeStrobes_t        strobes,
  output logic                resetPulse,
  output logic                deltaLoadStart,
  output logic                prefixLoadStart,
  output logic                commonLoadStart,
  output logic                execStart
);

  logic [OP_W-1:0]   opField;
  logic [ADDR_W-1:0] tgtField;
  logic              answerPending;
  logic              takeNow;
  logic              hitMe;
  logic              actNow;
  logic              emitNow;

  assign opField  = upCmd[OP_LSB +: OP_W];
  assign tgtField = upCmd[ID_LSB +: ADDR_W];
  assign hitMe    = (tgtField == nodeId) || (tgtField == ADDR_W'(BCAST_ID));

  // the slot after a read belongs to the answer word
  assign takeNow = !downBusy && !answerPending;
  assign emitNow = !downBusy && answerPending;
  assign actNow  = takeNow && hitMe;
  assign upBusy  = downBusy || answerPending;

  always_comb begin
    strobes         = '0;
    strobes.take    = takeNow;
    strobes.emit    = emitNow;
    strobes.idx     = upCmd[IDX_LSB +: IDX_W];
    strobes.wrEn    = actNow && (opField == OP_WRITE);
    strobes.clear   = actNow && (opField == OP_SOFTRST);
    strobes.capture = actNow && (opField == OP_READ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      answerPending <= 1'b0;
    end else if (strobes.capture) begin
      answerPending <= 1'b1;
    end else if (emitNow) begin
      answerPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetPulse      <= 1'b0;
      deltaLoadStart  <= 1'b0;
      prefixLoadStart <= 1'b0;
      commonLoadStart <= 1'b0;
      execStart       <= 1'b0;
    end else begin
      resetPulse      <= actNow && (opField == OP_SOFTRST);
      deltaLoadStart  <= actNow && (opField == OP_LDDELTA);
      prefixLoadStart <= actNow && (opField == OP_LDPREFIX);
      commonLoadStart <= actNow && (opField == OP_LDCOMMON);
      execStart       <= actNow && (opField == OP_EXEC);
    end
  end

endmodule

// File: rtl/cmd_chain_dp.sv
module cmd_chain_dp
  import cmd_chain_pkg::*;
#(
  parameter int NUM_REGS = 14,
  parameter int REG_W    = 48,
  parameter int ADDR_W   = ID_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         nodeId,
  input  logic [CMD_W-1:0]          upCmd,
  input  nodeStrobes_t              strobes,
  output logic [CMD_W-1:0]          downCmd,
  output logic [NUM_REGS*REG_W-1:0] cfgRegs
);

  localparam int PAD_W = PAY_W - REG_W;

  logic [REG_W-1:0] bank [NUM_REGS];
  logic [REG_W-1:0] readVal;
  logic [CMD_W-1:0] answerWord;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bank[i] <= '0;
      end else if (strobes.clear) begin
        bank[i] <= '0;
      end else if (strobes.wrEn && (strobes.idx == MY_IDX)) begin
        bank[i] <= upCmd[REG_W-1:0];
      end
    end
    assign cfgRegs[i*REG_W +: REG_W] = bank[i];
  end

  // out-of-range indices read as zero
  always_comb begin
    readVal = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (strobes.idx == IDX_W'(k)) readVal = bank[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      answerWord <= '0;
    end else if (strobes.capture) begin
      answerWord <= {OP_ANSWER, nodeId, strobes.idx, {PAD_W{1'b0}}, readVal};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      downCmd <= '0;
    end else if (strobes.emit) begin
      downCmd <= answerWord;
    end else if (strobes.take) begin
      downCmd <= upCmd;
    end
  end

endmodule

// File: rtl/cmd_chain_node.sv
module cmd_chain_node
  import cmd_chain_pkg::*;
#(
  parameter int          NUM_REGS = 14,
  parameter int          REG_W    = 48,
  parameter logic [4:0]  BCAST_ID = 5'd31
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ID_W-1:0]           nodeId,
  input  logic [CMD_W-1:0]          upCmd,
  output logic                      upBusy,
  output logic [CMD_W-1:0]          downCmd,
  input  logic                      downBusy,
  output logic [NUM_REGS*REG_W-1:0] cfgRegs,
  output logic                      resetPulse,
  output logic                      deltaLoadStart,
  output logic                      prefixLoadStart,
  output logic                      commonLoadStart,
  output logic                      execStart
);

  nodeStrobes_t strobes;

  cmd_chain_ctrl #(
    .ADDR_W   (ID_W),
    .BCAST_ID (BCAST_ID)
  ) u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .nodeId          (nodeId),
    .upCmd           (upCmd),
    .downBusy        (downBusy),
    .upBusy          (upBusy),
    .strobes         (strobes),
    .resetPulse      (resetPulse),
    .deltaLoadStart  (deltaLoadStart),
    .prefixLoadStart (prefixLoadStart),
    .commonLoadStart (commonLoadStart),
    .execStart       (execStart)
  );

  cmd_chain_dp #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .ADDR_W   (ID_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .nodeId  (nodeId),
    .upCmd   (upCmd),
    .strobes (strobes),
    .downCmd (downCmd),
    .cfgRegs (cfgRegs)
  );

endmodule

// File: rtl/cmd_chain_node_chk.sv
module cmd_chain_node_chk (
  input logic        clk,
  input logic        rstN,
  input logic [4:0]  nodeId,
  input logic [63:0] upCmd,
  input logic        upBusy,
  input logic [63:0] downCmd,
  input logic        downBusy,
  input logic        resetPulse,
  input logic        deltaLoadStart,
  input logic        prefixLoadStart,
  input logic        commonLoadStart,
  input logic        execStart
);

  logic hitIn;
  assign hitIn = (upCmd[59:55] == nodeId) || (upCmd[59:55] == 5'd31);

  p_forward_r2: assert property (@(posedge clk) disable iff (!rstN)
    !upBusy |=> (downCmd == $past(upCmd)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    downBusy |=> $stable(downCmd));

  p_busy_pass_r9: assert property (@(posedge clk) disable iff (!rstN)
    downBusy |-> upBusy);

  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetPulse, deltaLoadStart, prefixLoadStart, commonLoadStart, execStart}));

  p_exec_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!upBusy && hitIn && upCmd[63:60] == 4'd6) |=> execStart);

  p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!upBusy && hitIn && upCmd[63:60] == 4'd1) |=> resetPulse);

  p_answer_slot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!upBusy && hitIn && upCmd[63:60] == 4'd7) |=> upBusy);

  p_answer_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!upBusy && hitIn && upCmd[63:60] == 4'd7) |=> ##1
      (downBusy || (downCmd[63:60] == 4'd8 && downCmd[59:55] == nodeId)));

endmodule

bind cmd_chain_node cmd_chain_node_chk u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .nodeId          (nodeId),
  .upCmd           (upCmd),
  .upBusy          (upBusy),
  .downCmd         (downCmd),
  .downBusy        (downBusy),
  .resetPulse      (resetPulse),
  .deltaLoadStart  (deltaLoadStart),
  .prefixLoadStart (prefixLoadStart),
  .commonLoadStart (commonLoadStart),
  .execStart       (execStart)
);

// File: tb/cmd_chain_node_test.sv
module cmd_chain_node_test;

  localparam int NREG = 14;
  localparam int RW   = 48;
  localparam logic [4:0] MY_ID = 5'd5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [4:0]      nodeId = MY_ID;
  logic [63:0]     upCmd = '0;
  logic            upBusy;
  logic [63:0]     downCmd;
  logic            downBusy = 1'b0;
  logic [NREG*RW-1:0] cfgRegs;
  logic            resetPulse, deltaLoadStart, prefixLoadStart, commonLoadStart, execStart;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmd_chain_node uut (
    .clk             (clk),
    .rstN            (rstN),
    .nodeId          (nodeId),
    .upCmd           (upCmd),
    .upBusy          (upBusy),
    .downCmd         (downCmd),
    .downBusy        (downBusy),
    .cfgRegs         (cfgRegs),
    .resetPulse      (resetPulse),
    .deltaLoadStart  (deltaLoadStart),
    .prefixLoadStart (prefixLoadStart),
    .commonLoadStart (commonLoadStart),
    .execStart       (execStart)
  );

  function automatic logic [63:0] mk(input logic [3:0] op, input logic [4:0] id,
                                     input logic [3:0] idx, input logic [50:0] pay);
    return {op, id, idx, pay};
  endfunction

  function automatic logic [63:0] answer(input logic [3:0] idx, input logic [47:0] val);
    return {4'h8, MY_ID, idx, 3'b000, val};
  endfunction

  function automatic logic [47:0] regOf(input int i);
    return cfgRegs[i*RW +: RW];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] c);
    @(negedge clk);
    upCmd = c;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] pulses();
    return {59'd0, resetPulse, deltaLoadStart, prefixLoadStart, commonLoadStart, execStart};
  endfunction

  // write vectors, each followed by a readback of the same index
  localparam int NV = 6;
  localparam logic [63:0] VEC_CMD [NV] = '{
    {4'h2, 5'd5,  4'd0,  51'h0_1234_5678_9ABC},
    {4'h2, 5'd5,  4'd13, 51'h0_FFFF_FFFF_FFFF},
    {4'h2, 5'd31, 4'd7,  51'h0_0000_0000_0001},
    {4'h2, 5'd6,  4'd3,  51'h0_0000_0000_AAAA},
    {4'h2, 5'd5,  4'd14, 51'h0_0000_0000_5555},
    {4'h2, 5'd5,  4'd0,  51'h7_0000_0000_0042}
  };
  localparam logic [47:0] VEC_EXP [NV] = '{
    48'h1234_5678_9ABC, 48'hFFFF_FFFF_FFFF, 48'h0000_0000_0001,
    48'h0, 48'h0, 48'h0000_0000_0042
  };

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] held;
    logic [63:0] rd;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "downCmd", downCmd, 64'd0);
    check("R1", "upBusy", {63'd0, upBusy}, 64'd0);
    check("R1", "pulses", pulses(), 64'd0);
    check("R1", "regs", {63'd0, |cfgRegs}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1", "downCmd after release", downCmd, 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] ix;
      ix = VEC_CMD[v][54:51];
      drive(VEC_CMD[v]);
      check("R2", "write forwarded", downCmd, VEC_CMD[v]);
      if (ix < 4'd14)
        check((v == 3) ? "R5" : "R4", "bank value", {16'd0, regOf(int'(ix))}, {16'd0, VEC_EXP[v]});
      rd = mk(4'h7, MY_ID, ix, 51'd0);
      drive(rd);
      check("R6", "read forwarded", downCmd, rd);
      check("R6", "busy during answer slot", {63'd0, upBusy}, 64'd1);
      drive(64'd0);
      check((v == 3 || v == 4) ? "R5" : "R4", "answer word", downCmd, answer(ix, VEC_EXP[v]));
      check("R6", "busy released", {63'd0, upBusy}, 64'd0);
    end

    // R10: a write offered while an answer waits is held, then applied
    drive(mk(4'h7, MY_ID, 4'd0, 51'd0));
    held = mk(4'h2, MY_ID, 4'd1, 51'h77);
    drive(held);
    check("R10", "answer sent first", downCmd, answer(4'd0, 48'h42));
    check("R10", "held write not applied yet", {16'd0, regOf(1)}, 64'd0);
    @(posedge clk);
    #1;
    check("R10", "held write forwarded", downCmd, held);
    check("R10", "held write applied", {16'd0, regOf(1)}, 64'h77);

    // R9: downstream busy freezes the node
    @(negedge clk);
    downBusy = 1'b1;
    upCmd = mk(4'h2, MY_ID, 4'd2, 51'h9);
    @(posedge clk);
    #1;
    check("R9", "output frozen", downCmd, held);
    check("R9", "busy passed upstream", {63'd0, upBusy}, 64'd1);
    check("R9", "word not taken", {16'd0, regOf(2)}, 64'd0);
    @(negedge clk);
    downBusy = 1'b0;
    @(posedge clk);
    #1;
    check("R9", "word taken after release", downCmd, mk(4'h2, MY_ID, 4'd2, 51'h9));
    check("R9", "write applied after release", {16'd0, regOf(2)}, 64'h9);

    // R8: phase start pulses
    for (int op = 3; op <= 6; op++) begin
      drive(mk(4'(op), MY_ID, 4'd0, 51'd0));
      check("R8", "start pulse", pulses(), 64'(5'b1 << (6 - op)));
      drive(64'd0);
      check("R8", "pulse lasts one cycle", pulses(), 64'd0);
    end

    // R3: foreign target gives no pulse; unknown opcode and foreign answer forwarded
    drive(mk(4'h6, 5'd9, 4'd0, 51'd0));
    check("R3", "foreign exec ignored", pulses(), 64'd0);
    drive(mk(4'h9, MY_ID, 4'd3, 51'h1));
    check("R2", "unknown opcode forwarded", downCmd, mk(4'h9, MY_ID, 4'd3, 51'h1));
    drive(mk(4'h8, MY_ID, 4'd4, 51'h2));
    check("R2", "answer word forwarded", downCmd, mk(4'h8, MY_ID, 4'd4, 51'h2));
    check("R2", "no busy on passing answer", {63'd0, upBusy}, 64'd0);

    // R7: broadcast soft reset
    drive(mk(4'h1, 5'd31, 4'd0, 51'd0));
    check("R7", "reset pulse", pulses(), 64'h10);
    check("R7", "bank cleared", {63'd0, |cfgRegs}, 64'd0);
    drive(64'd0);
    check("R7", "reset pulse ends", pulses(), 64'd0);

    summary();
  end

endmodule